// File: doc/BRIEF.md
# Inbound Message Frame Queue

This block manages the receive ring for incoming mailbox messages. The ring lives in local memory as a run of equal frames, each 4 KB, and its length is a power of two between 2 and 2048 frames. Two address registers track it: the enqueue pointer names the frame that the next arriving message is written into, and the dequeue pointer names the oldest frame that software has not yet consumed. When the receive interface presents a good message, the block issues one write request for the frame at the enqueue pointer and moves that pointer forward by one frame, wrapping at the ring end.

Software loads both pointers with the ring base while the unit is off, sets the ring size and turns the unit on through the mode register. It then reads frames at the dequeue pointer and hands each one back by writing the mode register with its release bit set. Three sticky status flags (message queued, queue full, reception error) are cleared by writing ones, and any of them raises the interrupt output.

Top module: `fq_inbound_queue`

## Requirements
- R1: After reset the mode, status and both pointer registers read 0, irq is 0 and wr_req is 0.
- R2: Register 0 (mode) bit 0 enables the unit and bits 15:12 hold a size code f, giving 2^(f+1) frames (codes above 10 act as 2048); bit 1 always reads back 0.
- R3: A write to register 2 (dequeue pointer) or register 3 (enqueue pointer) while the unit is off loads that pointer and the ring base with the written address; such writes while the unit is on are ignored.
- R4: A message with msg_valid=1 and msg_err=0, while enabled and not full, raises wr_req in the same cycle with wr_addr equal to the enqueue pointer; the next cycle the enqueue pointer is one frame (4096) further on, back at the base after the last frame, and status bit 0 (queued) is set.
- R5: The queue is empty when the pointers are equal and full when one more advance of the enqueue pointer would make them equal, so a ring of N frames holds N-1; a good message arriving while full is dropped with no wr_req, the enqueue pointer unchanged and status bit 4 (full) set. Fullness is judged before a release in the same cycle.
- R6: A mode write with bit 1 set, while enabled and not empty, moves the dequeue pointer forward one frame with the same wrap; on an empty queue it has no effect.
- R7: A message with msg_valid=1 and msg_err=1 while enabled sets status bit 7 (error) and issues no write.
- R8: Writing 1 to a status bit clears it (0x91 clears all three); a set in the same cycle wins, and the queued flag is set again every cycle the enabled queue is non-empty.
- R9: deq_index equals (dequeue pointer - ring base) / 4096.
- R10: irq is 1 exactly when any status flag is set.
- R11: While the unit is off, msg_valid has no effect: no wr_req and no flag set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 mode, 1 status, 2 dequeue pointer, 3 enqueue pointer |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data of the selected register |
| msg_valid | input | 1 | A message has arrived this cycle |
| msg_err | input | 1 | The arriving message had a reception error |
| wr_req | output | 1 | Frame write request |
| wr_addr | output | 32 | Frame address of the write request |
| irq | output | 1 | Interrupt, any status flag set |
| deq_index | output | 11 | Frame number at the dequeue pointer |

## Verification
The interesting collision is a frame release by software and a message arrival in the same cycle while the ring is full. The bench fills a four-frame ring to three frames, then in one cycle writes the mode register with the release bit and presents a good message. It expects the message dropped (no write request, enqueue pointer unchanged, full flag set) while the dequeue pointer still moves, and it also clears status while frames remain to see the queued flag come straight back.

// File: rtl/fq_pkg.sv
package fq_pkg;

    localparam int ADDR_W   = 32;
    localparam int FRAME_SH = 12;
    localparam int MAX_LOG  = 11;
    localparam int SZ_W     = 4;

    typedef enum logic [1:0] {
        SEL_MODE = 2'd0,
        SEL_STAT = 2'd1,
        SEL_DEQ  = 2'd2,
        SEL_ENQ  = 2'd3
    } reg_sel_e;

    localparam int BIT_ERR  = 7;
    localparam int BIT_FULL = 4;
    localparam int BIT_QUE  = 0;
    localparam int BIT_EN   = 0;
    localparam int BIT_REL  = 1;
    localparam int SZ_LSB   = 12;

    typedef struct packed {
        logic err;
        logic full;
        logic que;
    } flags_t;

    function automatic int ring_log(input int code, input int max_log);
        return (code >= max_log) ? max_log : code + 1;
    endfunction

endpackage

// File: rtl/fq_ring_ptr.sv
module fq_ring_ptr #(
    parameter int ADDR_W   = 32,
    parameter int FRAME_SH = 12,
    parameter int IDX_W    = 11
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_val,
    input  logic              adv,
    input  logic [ADDR_W-1:0] base,
    input  logic [IDX_W-1:0]  mask,
    output logic [ADDR_W-1:0] ptr,
    output logic [IDX_W-1:0]  idx,
    output logic [IDX_W-1:0]  nidx
);
    logic [ADDR_W-1:0] ofs;
    logic [ADDR_W-1:0] nptr;

    always_comb begin
        ofs  = ptr - base;
        idx  = IDX_W'(ofs >> FRAME_SH);
        nidx = (idx + 1'b1) & mask;
        nptr = base + (ADDR_W'(nidx) << FRAME_SH);
    end

    always_ff @(posedge clk) begin
        if (rst)       ptr <= '0;
        else if (load) ptr <= load_val;
        else if (adv)  ptr <= nptr;
    end
endmodule

// File: rtl/fq_flags.sv
module fq_flags
    import fq_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  flags_t set_i,
    input  flags_t clr_i,
    output flags_t q
);
    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= (q & ~clr_i) | set_i;
    end
endmodule

// File: rtl/fq_inbound_queue.sv
module fq_inbound_queue
    import fq_pkg::*;
#(
    parameter int P_ADDR_W   = ADDR_W,
    parameter int P_FRAME_SH = FRAME_SH,
    parameter int P_MAX_LOG  = MAX_LOG,
    parameter int P_SZ_W     = SZ_W
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  reg_we,
    input  logic [1:0]            reg_addr,
    input  logic [P_ADDR_W-1:0]   reg_wdata,
    output logic [P_ADDR_W-1:0]   reg_rdata,
    input  logic                  msg_valid,
    input  logic                  msg_err,
    output logic                  wr_req,
    output logic [P_ADDR_W-1:0]   wr_addr,
    output logic                  irq,
    output logic [P_MAX_LOG-1:0]  deq_index
);
    localparam int IDX_W = P_MAX_LOG;

    reg_sel_e            sel;
    logic                mode_en;
    logic [P_SZ_W-1:0]   mode_sz;
    logic [P_ADDR_W-1:0] base;
    logic [IDX_W-1:0]    mask;
    logic [P_ADDR_W-1:0] enq_ptr, deq_ptr;
    logic [IDX_W-1:0]    enq_idx, enq_nidx, deq_idx, deq_nidx;
    logic                empty, full, accept, release_f, load_enq, load_deq;
    logic                wr_mode;
    flags_t              flag_set, flag_clr, flag_q;

    assign sel     = reg_sel_e'(reg_addr);
    assign wr_mode = reg_we && (sel == SEL_MODE);

    always_comb begin
        int lg;
        lg   = ring_log(int'(mode_sz), P_MAX_LOG);
        mask = IDX_W'((32'd1 << lg) - 32'd1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_en <= 1'b0;
            mode_sz <= '0;
            base    <= '0;
        end else begin
            if (wr_mode) begin
                mode_en <= reg_wdata[BIT_EN];
                mode_sz <= reg_wdata[SZ_LSB +: P_SZ_W];
            end
            if (load_enq || load_deq) base <= reg_wdata;
        end
    end

    assign load_deq = reg_we && !mode_en && (sel == SEL_DEQ);
    assign load_enq = reg_we && !mode_en && (sel == SEL_ENQ);

    assign empty     = (enq_ptr == deq_ptr);
    assign full      = (enq_nidx == deq_idx);
    assign accept    = msg_valid && !msg_err && mode_en && !full;
    assign release_f = wr_mode && reg_wdata[BIT_REL] && mode_en && !empty;

    fq_ring_ptr #(.ADDR_W(P_ADDR_W), .FRAME_SH(P_FRAME_SH), .IDX_W(IDX_W)) u_enq (
        .clk(clk), .rst(rst), .load(load_enq), .load_val(reg_wdata), .adv(accept),
        .base(base), .mask(mask), .ptr(enq_ptr), .idx(enq_idx), .nidx(enq_nidx)
    );

    fq_ring_ptr #(.ADDR_W(P_ADDR_W), .FRAME_SH(P_FRAME_SH), .IDX_W(IDX_W)) u_deq (
        .clk(clk), .rst(rst), .load(load_deq), .load_val(reg_wdata), .adv(release_f),
        .base(base), .mask(mask), .ptr(deq_ptr), .idx(deq_idx), .nidx(deq_nidx)
    );

    always_comb begin
        flag_set.que  = accept || (mode_en && !empty);
        flag_set.full = msg_valid && !msg_err && mode_en && full;
        flag_set.err  = msg_valid && msg_err && mode_en;
        flag_clr      = '0;
        if (reg_we && (sel == SEL_STAT)) begin
            flag_clr.err  = reg_wdata[BIT_ERR];
            flag_clr.full = reg_wdata[BIT_FULL];
            flag_clr.que  = reg_wdata[BIT_QUE];
        end
    end

    fq_flags u_flags (.clk(clk), .rst(rst), .set_i(flag_set), .clr_i(flag_clr), .q(flag_q));

    always_comb begin
        reg_rdata = '0;
        unique case (sel)
            SEL_MODE: begin
                reg_rdata[BIT_EN]               = mode_en;
                reg_rdata[SZ_LSB +: P_SZ_W]     = mode_sz;
            end
            SEL_STAT: begin
                reg_rdata[BIT_ERR]  = flag_q.err;
                reg_rdata[BIT_FULL] = flag_q.full;
                reg_rdata[BIT_QUE]  = flag_q.que;
            end
            SEL_DEQ:  reg_rdata = deq_ptr;
            SEL_ENQ:  reg_rdata = enq_ptr;
            default:  reg_rdata = '0;
        endcase
    end

    assign wr_req    = accept;
    assign wr_addr   = enq_ptr;
    assign irq       = |flag_q;
    assign deq_index = deq_idx;

    logic unused_ok;
    assign unused_ok = ^{enq_idx, deq_nidx};

endmodule

// File: rtl/fq_inbound_queue_chk.sv
module fq_inbound_queue_chk
    import fq_pkg::*;
#(
    parameter int AW = 32
) (
    input logic          clk,
    input logic          rst,
    input logic          msg_valid,
    input logic          msg_err,
    input logic          wr_req,
    input logic          en,
    input logic          full,
    input logic          empty,
    input logic [AW-1:0] enq_ptr,
    input logic [AW-1:0] deq_ptr,
    input flags_t        flags
);
    p_drop_when_full_r5: assert property (@(posedge clk) disable iff (rst)
        (en && full && msg_valid && !msg_err) |=> ($stable(enq_ptr) && flags.full));

    p_accept_advances_r4: assert property (@(posedge clk) disable iff (rst)
        wr_req |=> ((enq_ptr != $past(enq_ptr)) && flags.que));

    p_quiet_when_off_r11: assert property (@(posedge clk) disable iff (rst)
        !en |-> !wr_req);

    p_error_flag_r7: assert property (@(posedge clk) disable iff (rst)
        (en && msg_valid && msg_err) |=> flags.err);

    p_requeue_r8: assert property (@(posedge clk) disable iff (rst)
        (en && !empty) |=> flags.que);

    p_no_release_empty_r6: assert property (@(posedge clk) disable iff (rst)
        (en && empty) |=> $stable(deq_ptr));
endmodule

bind fq_inbound_queue fq_inbound_queue_chk #(.AW(P_ADDR_W)) chk_i (
    .clk(clk), .rst(rst), .msg_valid(msg_valid), .msg_err(msg_err),
    .wr_req(wr_req), .en(mode_en), .full(full), .empty(empty),
    .enq_ptr(enq_ptr), .deq_ptr(deq_ptr), .flags(flag_q)
);

// File: tb/fq_inbound_queue_tb_top.sv
`timescale 1ns/100ps
module fq_inbound_queue_tb_top;
    localparam logic [31:0] F  = 32'd4096;
    localparam logic [31:0] B  = 32'h0010_0000;
    localparam logic [31:0] B2 = 32'h0020_0000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_we = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        msg_valid = 1'b0;
    logic        msg_err = 1'b0;
    logic        wr_req;
    logic [31:0] wr_addr;
    logic        irq;
    logic [10:0] deq_index;

    int n_chk = 0;
    int n_bad = 0;
    logic [31:0] exp_q[$];
    logic [31:0] v;

    always #2 clk = ~clk;

    fq_inbound_queue dut_i (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .msg_valid(msg_valid),
        .msg_err(msg_err), .wr_req(wr_req), .wr_addr(wr_addr), .irq(irq),
        .deq_index(deq_index)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step(input logic we, input logic [1:0] a, input logic [31:0] d,
                        input logic mv, input logic me);
        @(negedge clk);
        reg_we = we; reg_addr = a; reg_wdata = d; msg_valid = mv; msg_err = me;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] val);
        step(1'b0, a, 32'd0, 1'b0, 1'b0);
        #1 val = reg_rdata;
    endtask

    task automatic send(input logic accepted, input logic [31:0] addr);
        step(1'b0, 2'd0, 32'd0, 1'b1, 1'b0);
        if (accepted) exp_q.push_back(addr);
    endtask

    // monitor: scoreboard of frame write requests
    always begin
        @(negedge clk);
        #1;
        if (!rst) begin
            if (wr_req) begin
                if (exp_q.size() == 0) begin
                    chk("R4/R5/R11 unexpected write", wr_addr, 32'hxxxx_xxxx);
                end else begin
                    chk("R4 write address", wr_addr, exp_q.pop_front());
                end
            end
        end
    end

    initial begin
        #400000;
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;

        rd(2'd0, v); chk("R1 mode", v, 32'd0);
        rd(2'd1, v); chk("R1 status", v, 32'd0);
        rd(2'd3, v); chk("R1 enq", v, 32'd0);
        chk("R1 irq", {31'd0, irq}, 32'd0);
        chk("R1 wr_req", {31'd0, wr_req}, 32'd0);

        send(1'b0, 32'd0);
        rd(2'd1, v); chk("R11 status while off", v, 32'd0);

        step(1'b1, 2'd2, B, 1'b0, 1'b0);
        step(1'b1, 2'd3, B, 1'b0, 1'b0);
        rd(2'd2, v); chk("R3 deq load", v, B);
        rd(2'd3, v); chk("R3 enq load", v, B);

        step(1'b1, 2'd0, 32'h0000_1001, 1'b0, 1'b0);
        rd(2'd0, v); chk("R2 mode readback", v, 32'h0000_1001);

        step(1'b1, 2'd2, 32'h0000_5000, 1'b0, 1'b0);
        rd(2'd2, v); chk("R3 write ignored while on", v, B);

        send(1'b1, B);
        send(1'b1, B + F);
        send(1'b1, B + 2*F);
        rd(2'd3, v); chk("R4 enq advance", v, B + 3*F);
        rd(2'd1, v); chk("R4 queued flag", v, 32'h01);
        chk("R10 irq on flag", {31'd0, irq}, 32'd1);

        send(1'b0, 32'd0);
        rd(2'd3, v); chk("R5 enq held when full", v, B + 3*F);
        rd(2'd1, v); chk("R5 full flag", v, 32'h11);

        step(1'b1, 2'd1, 32'h91, 1'b0, 1'b0);
        rd(2'd1, v); chk("R8 clear then requeue", v, 32'h01);

        step(1'b1, 2'd0, 32'h0000_1003, 1'b0, 1'b0);
        rd(2'd2, v); chk("R6 release", v, B + F);
        chk("R9 deq_index", {21'd0, deq_index}, 32'd1);
        rd(2'd0, v); chk("R2 release bit reads 0", v, 32'h0000_1001);

        send(1'b1, B + 3*F);
        rd(2'd3, v); chk("R4 enq wrap", v, B);

        step(1'b1, 2'd0, 32'h0000_1003, 1'b1, 1'b0);
        rd(2'd3, v); chk("R5 same-cycle drop", v, B);
        rd(2'd2, v); chk("R6 same-cycle release", v, B + 2*F);
        chk("R9 deq_index after release", {21'd0, deq_index}, 32'd2);

        step(1'b0, 2'd0, 32'd0, 1'b1, 1'b1);
        rd(2'd1, v); chk("R7 error flag", v, 32'h91);
        rd(2'd3, v); chk("R7 no advance on error", v, B);

        step(1'b1, 2'd0, 32'h0000_1003, 1'b0, 1'b0);
        step(1'b1, 2'd0, 32'h0000_1003, 1'b0, 1'b0);
        rd(2'd2, v); chk("R6 release wrap", v, B);
        step(1'b1, 2'd0, 32'h0000_1003, 1'b0, 1'b0);
        rd(2'd2, v); chk("R6 release on empty ignored", v, B);

        step(1'b1, 2'd1, 32'h91, 1'b0, 1'b0);
        rd(2'd1, v); chk("R8 clear all when empty", v, 32'd0);
        chk("R10 irq low", {31'd0, irq}, 32'd0);

        step(1'b1, 2'd0, 32'h0, 1'b0, 1'b0);
        step(1'b1, 2'd2, B2, 1'b0, 1'b0);
        step(1'b1, 2'd3, B2, 1'b0, 1'b0);
        step(1'b1, 2'd0, 32'h0000_0001, 1'b0, 1'b0);
        send(1'b1, B2);
        send(1'b0, 32'd0);
        rd(2'd3, v); chk("R2 two-frame ring holds one", v, B2 + F);
        rd(2'd1, v); chk("R5 full on two-frame ring", v, 32'h11);
        chk("R9 deq_index new base", {21'd0, deq_index}, 32'd0);

        step(1'b0, 2'd0, 32'd0, 1'b0, 1'b0);
        chk("R4 scoreboard drained", exp_q.size(), 32'd0);

        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule